// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block holds the state of a seven-level priority interrupt system. Each level has a request bit, a channel-enable bit and an in-progress bit, and one global bit turns the whole system on or off. Level 1 has the highest priority and level 7 the lowest. Software changes the state by writing a control word. The word carries a seven-bit channel mask and a set of command bits. The current state can be read at any time as a status word.

The processor side asks for an interrupt with `take_req`. The block then picks the highest-priority level that is eligible and marks that level in progress. One cycle later it returns the level number and the address of the interrupt word for that level. The address is the exec base plus twice the level plus 040 octal. When a service routine ends, a `dismiss` strobe retires the in-progress level with the highest priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `status` is all zero, `grant_vld` is 0, `irq_pend` is 0 and `cw_illegal` is 0.
- R2: Control word layout, with level n mapped to mask bit 7-n (mask bits 6:0): bit 7 turns the masked channels off, bit 8 turns them on, bit 11 sets the masked requests and bit 12 drops them. When both bits of a pair are set, drop is applied before set and off is applied after on, so set wins and channel-off wins. Status bits 6:0 show the enables and status bits 22:16 show the requests, with level n at bit 7-n of each field.
- R3: Bit 10 of the control word turns the system on and bit 9 turns it off. Status bit 7 shows the system-on bit. Off is applied after on, so a word that carries both leaves the system off.
- R4: Bit 13 of the control word clears all state (requests, enables, in-progress bits and system-on). It is applied before every other command in the same word.
- R5: If any of bits 17:14 of a control word is nonzero, the write changes no state, and `cw_illegal` is high for exactly the cycle after that write.
- R6: A level is eligible only when the system is on, its channel is enabled and its request is set. `irq_pend` is high when some level is eligible and no grant is being output.
- R7: When `take_req` is sampled high with `irq_pend` high, `grant_vld` is high for the next cycle only. In that cycle `grant_lvl` is the lowest-numbered eligible level N, and `grant_addr` equals `base_addr` + 2N + 040 octal.
- R8: A grant of level N sets its in-progress bit, which is status bit 15-N (level 1 at weight 040000 octal, level 7 at 000400). A level whose own in-progress bit is set, or that of any higher-priority level, is not eligible.
- R9: `take_req` is ignored in the cycle in which `grant_vld` is high, even if a level is eligible.
- R10: `dismiss` clears only the in-progress bit of the lowest-numbered level that is in progress. With no level in progress, it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_wr | input | 1 | Control word write strobe |
| cw_data | input | 18 | Control word: mask, command bits, must-be-zero field |
| cw_illegal | output | 1 | Pulse after a rejected control word |
| status | output | 24 | Status word: enables, system-on, in-progress, requests |
| base_addr | input | 18 | Exec base address used to form the interrupt word address |
| take_req | input | 1 | Request to take the highest eligible interrupt |
| irq_pend | output | 1 | Some level is eligible and no grant is being output |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_lvl | output | 3 | Granted level, 1 to 7 |
| grant_addr | output | 18 | Interrupt word address of the granted level |
| dismiss | input | 1 | Retire the highest-priority in-progress level |

## Verification
State is either visible in `status` at once or shows up in the next grant. A corrupted enable, request or system-on bit appears in `status` one cycle after the write that caused it, and it also changes which level the next `take_req` grants. A wrong in-progress bit either blocks levels that should win or lets a level win twice. The bench sweeps all 127 nonzero request patterns and checks the granted level, the address and the in-progress bit for each one. This catches a priority or encoding error within one grant of the pattern that exposes it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned PI_LEVELS   = 7;
    localparam int unsigned PI_ADDR_W   = 18;
    localparam int unsigned PI_VEC_OFS  = 'o40;
    localparam int unsigned PI_MBZ_W    = 4;

    // offsets of the command bits above the channel mask
    localparam int unsigned CMD_CHAN_OFF = 0;
    localparam int unsigned CMD_CHAN_ON  = 1;
    localparam int unsigned CMD_SYS_OFF  = 2;
    localparam int unsigned CMD_SYS_ON   = 3;
    localparam int unsigned CMD_REQ_SET  = 4;
    localparam int unsigned CMD_REQ_DROP = 5;
    localparam int unsigned CMD_CLR_ALL  = 6;
    localparam int unsigned CMD_COUNT    = 7;

    typedef struct packed {
        logic clr_all;
        logic req_drop;
        logic req_set;
        logic sys_on;
        logic sys_off;
        logic chan_on;
        logic chan_off;
    } pi_cmd_t;

    function automatic pi_cmd_t pi_cmd_from_bits(input logic [CMD_COUNT-1:0] b);
        pi_cmd_t c;
        c.chan_off = b[CMD_CHAN_OFF];
        c.chan_on  = b[CMD_CHAN_ON];
        c.sys_off  = b[CMD_SYS_OFF];
        c.sys_on   = b[CMD_SYS_ON];
        c.req_set  = b[CMD_REQ_SET];
        c.req_drop = b[CMD_REQ_DROP];
        c.clr_all  = b[CMD_CLR_ALL];
        return c;
    endfunction

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_LVL = PI_LEVELS,
    parameter int unsigned MBZ_W   = PI_MBZ_W,
    localparam int unsigned CW_W   = NUM_LVL + CMD_COUNT + MBZ_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cw_wr,
    input  logic [CW_W-1:0]    cw_data,
    output logic [NUM_LVL-1:0] req,      // index 0 = level 1
    output logic [NUM_LVL-1:0] en,
    output logic               sys_on,
    output logic               clr_now,
    output logic               illegal
);
    logic [NUM_LVL-1:0] mask_l;
    logic [MBZ_W-1:0]   mbz;
    pi_cmd_t            cmd;
    logic               legal_wr;
    logic [NUM_LVL-1:0] req_n, en_n;
    logic               sys_n;

    // level n sits at mask bit NUM_LVL-n; flip so index 0 is level 1
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_mask
        assign mask_l[i] = cw_data[NUM_LVL-1-i];
    end

    assign cmd      = pi_cmd_from_bits(cw_data[NUM_LVL +: CMD_COUNT]);
    assign mbz      = cw_data[NUM_LVL+CMD_COUNT +: MBZ_W];
    assign legal_wr = cw_wr && (mbz == '0);
    assign clr_now  = legal_wr && cmd.clr_all;

    always_comb begin
        req_n = req;
        en_n  = en;
        sys_n = sys_on;
        if (legal_wr) begin
            if (cmd.clr_all) begin
                req_n = '0;
                en_n  = '0;
                sys_n = 1'b0;
            end
            if (cmd.req_drop) req_n = req_n & ~mask_l;
            if (cmd.req_set)  req_n = req_n | mask_l;
            if (cmd.sys_on)   sys_n = 1'b1;
            if (cmd.sys_off)  sys_n = 1'b0;
            if (cmd.chan_on)  en_n  = en_n | mask_l;
            if (cmd.chan_off) en_n  = en_n & ~mask_l;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= '0;
            en      <= '0;
            sys_on  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            req     <= req_n;
            en      <= en_n;
            sys_on  <= sys_n;
            illegal <= cw_wr && (mbz != '0);
        end
    end

    p_reject_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
        (cw_wr && (mbz != '0)) |=> ($stable(req) && $stable(en) && $stable(sys_on) && illegal));

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_LVL = PI_LEVELS,
    localparam int unsigned LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic               sys_on,
    input  logic [NUM_LVL-1:0] req,
    input  logic [NUM_LVL-1:0] en,
    input  logic [NUM_LVL-1:0] inprog,
    output logic               any_elig,
    output logic [NUM_LVL-1:0] win,
    output logic [LVL_W-1:0]   win_lvl
);
    logic [NUM_LVL-1:0] blocked;   // this level or a higher one in progress
    logic [NUM_LVL-1:0] elig;
    logic [NUM_LVL-1:0] above;     // a higher-priority level is eligible

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        if (i == 0) begin : g_first
            assign blocked[i] = inprog[i];
            assign above[i]   = 1'b0;
        end else begin : g_rest
            assign blocked[i] = blocked[i-1] | inprog[i];
            assign above[i]   = above[i-1] | elig[i-1];
        end
        assign elig[i] = sys_on & en[i] & req[i] & ~blocked[i];
        assign win[i]  = elig[i] & ~above[i];
    end

    assign any_elig = |elig;

    always_comb begin
        win_lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (win[i]) win_lvl = win_lvl | LVL_W'(i + 1);
        end
    end

endmodule

// File: rtl/prio_irq_active.sv
module prio_irq_active
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_LVL = PI_LEVELS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_now,
    input  logic               dismiss,
    input  logic [NUM_LVL-1:0] mark,
    output logic [NUM_LVL-1:0] inprog
);
    logic [NUM_LVL-1:0] seen;
    logic [NUM_LVL-1:0] retire;
    logic [NUM_LVL-1:0] base;

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_scan
        if (i == 0) begin : g_first
            assign seen[i] = 1'b0;
        end else begin : g_rest
            assign seen[i] = seen[i-1] | inprog[i-1];
        end
        assign retire[i] = dismiss & inprog[i] & ~seen[i];
    end

    assign base = clr_now ? '0 : (inprog & ~retire);

    always_ff @(posedge clk) begin
        if (rst) inprog <= '0;
        else     inprog <= base | mark;
    end

    p_dismiss_single_r10: assert property (@(posedge clk) disable iff (rst)
        (dismiss && !clr_now && mark == '0) |=>
        ($countones(inprog) == $countones($past(inprog)) - (($past(inprog) != '0) ? 1 : 0)));

    p_mark_adds_one_r8: assert property (@(posedge clk) disable iff (rst)
        (mark != '0 && !clr_now && !dismiss) |=>
        ($countones(inprog) == $countones($past(inprog)) + 1));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_LVL = PI_LEVELS,
    parameter int unsigned ADDR_W  = PI_ADDR_W,
    parameter int unsigned MBZ_W   = PI_MBZ_W,
    parameter int unsigned VEC_OFS = PI_VEC_OFS,
    localparam int unsigned CW_W   = NUM_LVL + CMD_COUNT + MBZ_W,
    localparam int unsigned ST_W   = 3 * NUM_LVL + 3,
    localparam int unsigned LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_wr,
    input  logic [CW_W-1:0]   cw_data,
    output logic              cw_illegal,
    output logic [ST_W-1:0]   status,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              take_req,
    output logic              irq_pend,
    output logic              grant_vld,
    output logic [LVL_W-1:0]  grant_lvl,
    output logic [ADDR_W-1:0] grant_addr,
    input  logic              dismiss
);
    localparam int unsigned IP_LO  = NUM_LVL + 1;
    localparam int unsigned REQ_LO = 2 * NUM_LVL + 2;

    logic [NUM_LVL-1:0] req, en, inprog, win, mark;
    logic               sys_on, clr_now, any_elig, take_ok;
    logic [LVL_W-1:0]   win_lvl;

    prio_irq_cfg #(.NUM_LVL(NUM_LVL), .MBZ_W(MBZ_W)) u_cfg (
        .clk(clk), .rst(rst), .cw_wr(cw_wr), .cw_data(cw_data),
        .req(req), .en(en), .sys_on(sys_on), .clr_now(clr_now),
        .illegal(cw_illegal)
    );

    prio_irq_pick #(.NUM_LVL(NUM_LVL)) u_pick (
        .sys_on(sys_on), .req(req), .en(en), .inprog(inprog),
        .any_elig(any_elig), .win(win), .win_lvl(win_lvl)
    );

    prio_irq_active #(.NUM_LVL(NUM_LVL)) u_active (
        .clk(clk), .rst(rst), .clr_now(clr_now), .dismiss(dismiss),
        .mark(mark), .inprog(inprog)
    );

    // the cycle that outputs a grant masks further takes
    assign take_ok  = take_req && !grant_vld && any_elig;
    assign mark     = take_ok ? win : '0;
    assign irq_pend = any_elig && !grant_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_vld  <= 1'b0;
            grant_lvl  <= '0;
            grant_addr <= '0;
        end else begin
            grant_vld <= take_ok;
            if (take_ok) begin
                grant_lvl  <= win_lvl;
                grant_addr <= base_addr + (ADDR_W'(win_lvl) << 1) + ADDR_W'(VEC_OFS);
            end
        end
    end

    // status: level n at bit NUM_LVL-n of each field
    always_comb begin
        status = '0;
        status[NUM_LVL] = sys_on;
        for (int i = 0; i < NUM_LVL; i++) begin
            status[NUM_LVL-1-i]        = en[i];
            status[IP_LO+NUM_LVL-1-i]  = inprog[i];
            status[REQ_LO+NUM_LVL-1-i] = req[i];
        end
    end

    p_grant_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        grant_vld |=> !grant_vld);

    p_grant_needs_on_r6: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> $past(sys_on));

    p_grant_marks_active_r8: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (grant_lvl >= 1 && grant_lvl <= NUM_LVL
                       && inprog[grant_lvl - 1'b1]));

    p_grant_level_range_r7: assert property (@(posedge clk) disable iff (rst)
        take_ok |=> (grant_lvl != '0));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam logic [17:0] COFF  = 18'h00080;
    localparam logic [17:0] CON   = 18'h00100;
    localparam logic [17:0] SOFF  = 18'h00200;
    localparam logic [17:0] SON   = 18'h00400;
    localparam logic [17:0] RSET  = 18'h00800;
    localparam logic [17:0] RDROP = 18'h01000;
    localparam logic [17:0] CLR   = 18'h02000;
    localparam logic [17:0] BASE  = 18'o1000;

    logic        clk = 0, rst = 1;
    logic        cw_wr = 0, take_req = 0, dismiss = 0;
    logic [17:0] cw_data = 0, base_addr = BASE;
    logic        cw_illegal, irq_pend, grant_vld;
    logic [23:0] status;
    logic [2:0]  grant_lvl;
    logic [17:0] grant_addr;
    int checks = 0, errors = 0;
    bit done = 0;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .cw_wr(cw_wr), .cw_data(cw_data),
        .cw_illegal(cw_illegal), .status(status), .base_addr(base_addr),
        .take_req(take_req), .irq_pend(irq_pend), .grant_vld(grant_vld),
        .grant_lvl(grant_lvl), .grant_addr(grant_addr), .dismiss(dismiss)
    );

    always #10 clk = ~clk;

    function automatic logic [17:0] lm(input int n);
        return 18'(1 << (7 - n));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] w);
        cw_wr = 1; cw_data = w;
        @(negedge clk);
        cw_wr = 0; cw_data = 0;
    endtask

    task automatic take();
        take_req = 1;
        @(negedge clk);
        take_req = 0;
    endtask

    task automatic dis();
        dismiss = 1;
        @(negedge clk);
        dismiss = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 0);
        chk("R1 grant_vld", 32'(grant_vld), 0);
        chk("R1 irq_pend", 32'(irq_pend), 0);
        chk("R1 cw_illegal", 32'(cw_illegal), 0);

        // R2 set+drop same word: set wins; on/off same word: off wins
        wr(RSET | RDROP | lm(2) | lm(5));
        chk("R2 set wins", 32'(status[22:16]), 32'(lm(2) | lm(5)));
        wr(RDROP | lm(2));
        chk("R2 drop", 32'(status[22:16]), 32'(lm(5)));
        wr(CON | 18'h7f);
        wr(CON | COFF | lm(3));
        chk("R2 chan off wins", 32'(status[6:0]), 32'(18'h7f & ~lm(3)));

        // R3 system on/off
        wr(SON);
        chk("R3 on", 32'(status[7]), 1);
        wr(SON | SOFF);
        chk("R3 off wins", 32'(status[7]), 0);

        // R6 system off: level 5 requested and enabled, not pending
        chk("R6 off no pend", 32'(irq_pend), 0);
        take();
        chk("R6 off no grant", 32'(grant_vld), 0);

        // R4 clear first, then set in same word
        wr(CLR | RSET | lm(4));
        chk("R4 clear then set", 32'(status), 32'(lm(4)) << 16);

        // R5 illegal write
        wr(18'h04000 | SON | CON | 18'h7f);
        chk("R5 illegal pulse", 32'(cw_illegal), 1);
        chk("R5 no change", 32'(status), 32'(lm(4)) << 16);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(cw_illegal), 0);

        // R6 requested but channel off is not eligible
        wr(SON | CON | lm(1));
        chk("R6 disabled not pend", 32'(irq_pend), 0);

        // R7/R8 sweep over every request pattern
        for (int m = 1; m < 128; m++) begin
            int lvl;
            lvl = 0;
            for (int n = 7; n >= 1; n--) if (m[7-n]) lvl = n;
            wr(CLR | SON | CON | RSET | 18'h7f);
            wr(RDROP | (18'h7f & ~18'(m)));
            take();
            chk("R7 vld", 32'(grant_vld), 1);
            chk("R7 level", 32'(grant_lvl), 32'(lvl));
            chk("R7 addr", 32'(grant_addr), 32'(BASE + 18'(2 * lvl) + 18'o40));
            chk("R8 inprog bit", 32'(status[14:8]), 32'(lm(lvl)));
            dis();
            chk("R10 dismissed", 32'(status[14:8]), 0);
        end

        // R9 take masked in grant cycle; R8 blocking
        wr(CLR | SON | CON | 18'h7f);
        wr(RSET | lm(3));
        take_req = 1;
        cw_wr = 1; cw_data = RSET | lm(1);
        @(negedge clk);
        cw_wr = 0; cw_data = 0;
        chk("R9 first grant", 32'(grant_lvl), 3);
        chk("R9 pend masked", 32'(irq_pend), 0);
        @(negedge clk);
        take_req = 0;
        chk("R9 take ignored", 32'(grant_vld), 0);
        chk("R9 only level3 active", 32'(status[14:8]), 32'(lm(3)));
        chk("R8 higher still pend", 32'(irq_pend), 1);
        take();
        chk("R8 level1 over active3", 32'(grant_lvl), 1);
        chk("R8 both active", 32'(status[14:8]), 32'(lm(1) | lm(3)));
        wr(RDROP | 18'h7f);
        wr(RSET | lm(5) | lm(2));
        chk("R8 blocked below active", 32'(irq_pend), 0);
        take();
        chk("R8 no grant when blocked", 32'(grant_vld), 0);

        // R10 dismiss highest only
        dis();
        chk("R10 level1 retired", 32'(status[14:8]), 32'(lm(3)));
        chk("R8 level2 now pend", 32'(irq_pend), 1);
        dis();
        chk("R10 level3 retired", 32'(status[14:8]), 0);
        dis();
        chk("R10 empty dismiss", 32'(status[14:8]), 0);
        chk("R10 other state kept", 32'(status[22:16]), 32'(lm(5) | lm(2)));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule